// File: doc/BRIEF.md
# Context-Tagged TLB Lookup Unit

A small fully associative translation cache that turns a virtual address into a physical address in the same cycle the request is presented. Every entry carries a virtual page tag, a physical page, an attribute byte (memory type plus access permissions), a page-size code, a translation-regime code, an address-space identifier (ASID), a global flag and a virtual-machine identifier (VMID). Because entries are tagged with their context, a switch of process or guest does not require flushing the cache.

A lookup compares the request against all entries at once. The address compare ignores the offset bits inside each entry's own page. The regime must always agree. The ASID and VMID are compared only when the current regime gives them meaning. Entries are filled through a write port by index, and a single invalidate-all input empties the whole array. If overlapping entries match together, the lowest-index one wins and a multi-hit flag is raised.

Top module: `ctlb_lookup`

## Requirements
- R1: After reset deassertion no entry is valid, so every lookup returns hit_o=0.
- R2: A write with wr_en_i=1 stores all fields at index wr_idx_i and marks it valid; a matching lookup in the following cycle hits.
- R3: The address compare covers lk_va_i bits 48 down to N, where the size code gives N: 0 is 4 KB (N=12), 1 is 2 MB (N=21) and 2 is 1 GB (N=30). An entry with size code 3 never hits.
- R4: On a hit, pa_o is the entry's physical bits above N joined with lk_va_i bits below N, and attr_o is the entry's attribute byte. On a miss, pa_o, attr_o and hit_vec_o are all zero.
- R5: An entry hits only when its regime code equals lk_regime_i. The codes are 0 Secure EL3, 1 Non-secure EL2/EL0, 2 Secure EL1/EL0 and 3 Non-secure EL1/EL0.
- R6: The ASID is relevant in regimes 2 and 3, and in regime 1 only when lk_e2h_i and lk_tge_i are both 1. When it is relevant, an entry hits only if its ASID equals lk_asid_i or its global flag is set.
- R7: When the ASID is not relevant (regime 0, or regime 1 without both control bits set), the ASID compare is skipped.
- R8: The VMID is compared only in regime 3. In every other regime it is ignored.
- R9: When more than one entry matches, multi_hit_o=1 and the outputs come from the lowest-index matching entry.
- R10: inv_all_i=1 clears every valid bit in one cycle and overrides a write in the same cycle.
- R11: hit_vec_o has at most one bit set, at the index of the selected entry, and hit_o equals the OR of hit_vec_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Fill strobe |
| wr_idx_i | input | 4 | Entry index to fill |
| wr_va_i | input | 49 | Virtual tag to store |
| wr_pa_i | input | 48 | Physical page to store |
| wr_attr_i | input | 8 | Memory type and permissions |
| wr_size_i | input | 2 | Page-size code |
| wr_regime_i | input | 2 | Regime code of the entry |
| wr_asid_i | input | 16 | ASID of the entry |
| wr_global_i | input | 1 | Entry matches any ASID |
| wr_vmid_i | input | 16 | VMID of the entry |
| inv_all_i | input | 1 | Invalidate every entry |
| lk_va_i | input | 49 | Lookup virtual address |
| lk_regime_i | input | 2 | Current regime |
| lk_asid_i | input | 16 | Current ASID |
| lk_vmid_i | input | 16 | Current VMID |
| lk_e2h_i | input | 1 | Hypervisor host-mode control bit |
| lk_tge_i | input | 1 | Hypervisor trap-general control bit |
| hit_o | output | 1 | Lookup hit |
| hit_vec_o | output | 16 | One-hot selected entry |
| multi_hit_o | output | 1 | More than one entry matched |
| pa_o | output | 48 | Translated physical address |
| attr_o | output | 8 | Attributes of the selected entry |

## Verification
The hardest case to reach is the multi-hit. The fill port accepts any contents, so a 1 GB entry is written at a higher index and covers a 4 KB entry already in place with the same context. The bench then checks both the overlapped address and an address that only the large page covers. ASID relevance in regime 1 is reached by presenting the same lookup with the two control bits in different states. An invalidate is issued in the same cycle as a write to show that the write is lost.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;
  localparam int VA_W   = 49;
  localparam int PA_W   = 48;
  localparam int ASID_W = 16;
  localparam int VMID_W = 16;
  localparam int ATTR_W = 8;

  typedef enum logic [1:0] {
    RG_S_EL3  = 2'd0,
    RG_NS_EL2 = 2'd1,
    RG_S_EL1  = 2'd2,
    RG_NS_EL1 = 2'd3
  } regime_e;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_1G   = 2'd2,
    PG_RSVD = 2'd3
  } pgsz_e;

  typedef struct packed {
    logic [VA_W-1:0]   va;
    logic [PA_W-1:0]   pa;
    logic [ATTR_W-1:0] attr;
    pgsz_e             size;
    regime_e           regime;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VMID_W-1:0] vmid;
  } entry_t;

  // offset mask inside the page
  function automatic logic [VA_W-1:0] va_off_mask(pgsz_e s);
    case (s)
      PG_2M:   return (VA_W'(1) << 21) - VA_W'(1);
      PG_1G:   return (VA_W'(1) << 30) - VA_W'(1);
      default: return (VA_W'(1) << 12) - VA_W'(1);
    endcase
  endfunction

  function automatic logic [PA_W-1:0] pa_off_mask(pgsz_e s);
    case (s)
      PG_2M:   return (PA_W'(1) << 21) - PA_W'(1);
      PG_1G:   return (PA_W'(1) << 30) - PA_W'(1);
      default: return (PA_W'(1) << 12) - PA_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ctlb_store.sv
module ctlb_store
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  entry_t                 wr_entry_i,
  input  logic                   inv_all_i,
  output logic [NUM_ENTRIES-1:0] valid_o,
  output entry_t                 entries_o [NUM_ENTRIES]
);
  logic [NUM_ENTRIES-1:0] valid_q;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        valid_q[i] <= 1'b0;
      else if (inv_all_i) valid_q[i] <= 1'b0;
      else if (sel)       valid_q[i] <= 1'b1;
    end

    // payload needs no reset; guarded by valid
    always_ff @(posedge clk_i) begin
      if (sel) entries_o[i] <= wr_entry_i;
    end
  end

  assign valid_o = valid_q;

  // R10
  inv_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (valid_o == '0));

  // R2
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inv_all_i) |=> valid_o[$past(wr_idx_i)]);
endmodule

// File: rtl/ctlb_match.sv
module ctlb_match
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  entry_t                 entries_i [NUM_ENTRIES],
  input  logic [VA_W-1:0]        va_i,
  input  regime_e                regime_i,
  input  logic [ASID_W-1:0]      asid_i,
  input  logic [VMID_W-1:0]      vmid_i,
  input  logic                   e2h_i,
  input  logic                   tge_i,
  output logic [NUM_ENTRIES-1:0] match_o
);
  logic asid_rel, vmid_rel;

  assign asid_rel = (regime_i == RG_S_EL1) || (regime_i == RG_NS_EL1) ||
                    ((regime_i == RG_NS_EL2) && e2h_i && tge_i);
  assign vmid_rel = (regime_i == RG_NS_EL1);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    entry_t          e;
    logic [VA_W-1:0] msk;
    logic va_ok, rg_ok, asid_ok, vmid_ok, sz_ok;

    assign e       = entries_i[i];
    assign msk     = va_off_mask(e.size);
    assign va_ok   = (((e.va ^ va_i) & ~msk) == '0);
    assign sz_ok   = (e.size != PG_RSVD);
    assign rg_ok   = (e.regime == regime_i);
    assign asid_ok = !asid_rel || e.glob || (e.asid == asid_i);
    assign vmid_ok = !vmid_rel || (e.vmid == vmid_i);
    assign match_o[i] = valid_i[i] && va_ok && sz_ok && rg_ok && asid_ok && vmid_ok;
  end
endmodule

// File: rtl/ctlb_select.sv
module ctlb_select
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0] match_i,
  input  logic [PA_W-1:0]        pa_i   [NUM_ENTRIES],
  input  logic [ATTR_W-1:0]      attr_i [NUM_ENTRIES],
  input  pgsz_e                  size_i [NUM_ENTRIES],
  input  logic [PA_W-1:0]        va_low_i,
  output logic                   hit_o,
  output logic [NUM_ENTRIES-1:0] vec_o,
  output logic                   multi_o,
  output logic [PA_W-1:0]        pa_o,
  output logic [ATTR_W-1:0]      attr_o
);
  logic [IDX_W-1:0] sel_idx;
  logic [PA_W-1:0]  msk;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) sel_idx = IDX_W'(i);
    end
  end

  assign hit_o   = |match_i;
  assign multi_o = |(match_i & (match_i - NUM_ENTRIES'(1)));
  assign vec_o   = hit_o ? (NUM_ENTRIES'(1) << sel_idx) : '0;
  assign msk     = pa_off_mask(size_i[sel_idx]);
  assign pa_o    = hit_o ? ((pa_i[sel_idx] & ~msk) | (va_low_i & msk)) : '0;
  assign attr_o  = hit_o ? attr_i[sel_idx] : '0;
endmodule

// File: rtl/ctlb_lookup.sv
module ctlb_lookup
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [VA_W-1:0]        wr_va_i,
  input  logic [PA_W-1:0]        wr_pa_i,
  input  logic [ATTR_W-1:0]      wr_attr_i,
  input  logic [1:0]             wr_size_i,
  input  logic [1:0]             wr_regime_i,
  input  logic [ASID_W-1:0]      wr_asid_i,
  input  logic                   wr_global_i,
  input  logic [VMID_W-1:0]      wr_vmid_i,
  input  logic                   inv_all_i,
  input  logic [VA_W-1:0]        lk_va_i,
  input  logic [1:0]             lk_regime_i,
  input  logic [ASID_W-1:0]      lk_asid_i,
  input  logic [VMID_W-1:0]      lk_vmid_i,
  input  logic                   lk_e2h_i,
  input  logic                   lk_tge_i,
  output logic                   hit_o,
  output logic [NUM_ENTRIES-1:0] hit_vec_o,
  output logic                   multi_hit_o,
  output logic [PA_W-1:0]        pa_o,
  output logic [ATTR_W-1:0]      attr_o
);
  entry_t                 wr_entry;
  entry_t                 entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid;
  logic [NUM_ENTRIES-1:0] match;
  logic [PA_W-1:0]        pa_arr   [NUM_ENTRIES];
  logic [ATTR_W-1:0]      attr_arr [NUM_ENTRIES];
  pgsz_e                  size_arr [NUM_ENTRIES];

  always_comb begin
    wr_entry.va     = wr_va_i;
    wr_entry.pa     = wr_pa_i;
    wr_entry.attr   = wr_attr_i;
    wr_entry.size   = pgsz_e'(wr_size_i);
    wr_entry.regime = regime_e'(wr_regime_i);
    wr_entry.asid   = wr_asid_i;
    wr_entry.glob   = wr_global_i;
    wr_entry.vmid   = wr_vmid_i;
  end

  ctlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .inv_all_i  (inv_all_i),
    .valid_o    (valid),
    .entries_o  (entries)
  );

  ctlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .valid_i   (valid),
    .entries_i (entries),
    .va_i      (lk_va_i),
    .regime_i  (regime_e'(lk_regime_i)),
    .asid_i    (lk_asid_i),
    .vmid_i    (lk_vmid_i),
    .e2h_i     (lk_e2h_i),
    .tge_i     (lk_tge_i),
    .match_o   (match)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_fan
    assign pa_arr[i]   = entries[i].pa;
    assign attr_arr[i] = entries[i].attr;
    assign size_arr[i] = entries[i].size;
  end

  ctlb_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_select (
    .match_i  (match),
    .pa_i     (pa_arr),
    .attr_i   (attr_arr),
    .size_i   (size_arr),
    .va_low_i (lk_va_i[PA_W-1:0]),
    .hit_o    (hit_o),
    .vec_o    (hit_vec_o),
    .multi_o  (multi_hit_o),
    .pa_o     (pa_o),
    .attr_o   (attr_o)
  );

  // R11
  vec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o) && (hit_o == (hit_vec_o != '0)));

  // R1
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((hit_vec_o & valid) != '0));

  // R9
  multi_implies_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> (hit_o && ($countones(match) > 1)));

  // R4
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> ((pa_o == '0) && (attr_o == '0)));

  // R10
  inv_then_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !hit_o);
endmodule

// File: tb/ctlb_lookup_tb.sv
module ctlb_lookup_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [48:0] wr_va_i = '0;
  logic [47:0] wr_pa_i = '0;
  logic [7:0]  wr_attr_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [1:0]  wr_regime_i = '0;
  logic [15:0] wr_asid_i = '0;
  logic        wr_global_i = 1'b0;
  logic [15:0] wr_vmid_i = '0;
  logic        inv_all_i = 1'b0;
  logic [48:0] lk_va_i = '0;
  logic [1:0]  lk_regime_i = '0;
  logic [15:0] lk_asid_i = '0;
  logic [15:0] lk_vmid_i = '0;
  logic        lk_e2h_i = 1'b0;
  logic        lk_tge_i = 1'b0;
  logic        hit_o;
  logic [15:0] hit_vec_o;
  logic        multi_hit_o;
  logic [47:0] pa_o;
  logic [7:0]  attr_o;

  ctlb_lookup u_dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    string       tag;
    logic        hit;
    logic        multi;
    logic [15:0] vec;
    logic [47:0] pa;
    logic [7:0]  attr;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  task automatic fill(input logic [3:0] idx, input logic [48:0] va, input logic [47:0] pa,
                      input logic [7:0] attr, input logic [1:0] sz, input logic [1:0] rg,
                      input logic [15:0] asid, input logic glob, input logic [15:0] vmid,
                      input logic inv);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_va_i = va; wr_pa_i = pa; wr_attr_i = attr;
    wr_size_i = sz; wr_regime_i = rg; wr_asid_i = asid; wr_global_i = glob;
    wr_vmid_i = vmid; inv_all_i = inv;
    @(negedge clk_i);
    wr_en_i = 1'b0; inv_all_i = 1'b0;
  endtask

  task automatic look(input string tag, input logic [48:0] va, input logic [1:0] rg,
                      input logic [15:0] asid, input logic [15:0] vmid,
                      input logic e2h, input logic tge,
                      input logic hit, input logic multi, input logic [15:0] vec,
                      input logic [47:0] pa, input logic [7:0] attr);
    exp_t x;
    @(negedge clk_i);
    lk_va_i = va; lk_regime_i = rg; lk_asid_i = asid; lk_vmid_i = vmid;
    lk_e2h_i = e2h; lk_tge_i = tge;
    x.tag = tag; x.hit = hit; x.multi = multi; x.vec = vec; x.pa = pa; x.attr = attr;
    q.push_back(x);
  endtask

  task automatic miss(input string tag, input logic [48:0] va, input logic [1:0] rg,
                      input logic [15:0] asid, input logic [15:0] vmid,
                      input logic e2h, input logic tge);
    look(tag, va, rg, asid, vmid, e2h, tge, 1'b0, 1'b0, 16'h0, 48'h0, 8'h0);
  endtask

  // monitor: compare mid low phase, after the driver has settled
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (q.size() != 0) begin
        exp_t x;
        x = q.pop_front();
        n_chk++;
        if (hit_o !== x.hit || multi_hit_o !== x.multi || hit_vec_o !== x.vec ||
            pa_o !== x.pa || attr_o !== x.attr) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b multi=%0b vec=%h pa=%h attr=%h exp hit=%0b multi=%0b vec=%h pa=%h attr=%h",
                   x.tag, hit_o, multi_hit_o, hit_vec_o, pa_o, attr_o,
                   x.hit, x.multi, x.vec, x.pa, x.attr);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: nothing valid after reset
    miss("R1 reset", 49'h0_1234_5678_9ABC, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0);

    // E0: 4 KB, regime 3, asid 5, vmid 7
    fill(4'd0, 49'h0_1234_5678_9000, 48'h0000_0ABC_D000, 8'h11, 2'd0, 2'd3, 16'd5, 1'b0, 16'd7, 1'b0);
    look("R2 R4 fill 4K", 49'h0_1234_5678_9ABC, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0,
         1'b1, 1'b0, 16'h0001, 48'h0000_0ABC_DABC, 8'h11);
    miss("R8 vmid mismatch regime3", 49'h0_1234_5678_9ABC, 2'd3, 16'd5, 16'd8, 1'b0, 1'b0);
    miss("R6 asid mismatch", 49'h0_1234_5678_9ABC, 2'd3, 16'd6, 16'd7, 1'b0, 1'b0);
    miss("R5 regime mismatch", 49'h0_1234_5678_9ABC, 2'd2, 16'd5, 16'd7, 1'b0, 1'b0);
    miss("R3 next 4K page", 49'h0_1234_5678_A000, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0);

    // E1: 2 MB global, regime 2, idx 3
    fill(4'd3, 49'h0_0000_4020_0000, 48'h0000_8060_0000, 8'h22, 2'd1, 2'd2, 16'd9, 1'b1, 16'd3, 1'b0);
    look("R3 R6 R8 2M global", 49'h0_0000_403F_FFF0, 2'd2, 16'd1, 16'd0, 1'b0, 1'b0,
         1'b1, 1'b0, 16'h0008, 48'h0000_807F_FFF0, 8'h22);
    miss("R3 beyond 2M", 49'h0_0000_4040_0000, 2'd2, 16'd1, 16'd0, 1'b0, 1'b0);

    // E2: 1 GB, regime 1, asid 4, idx 5, VA bit 48 set
    fill(4'd5, 49'h1_0000_4000_0000, 48'h0012_C000_0000, 8'h33, 2'd2, 2'd1, 16'd4, 1'b0, 16'd0, 1'b0);
    look("R7 regime1 e2h=0", 49'h1_0000_7FFF_1234, 2'd1, 16'd9, 16'd0, 1'b0, 1'b1,
         1'b1, 1'b0, 16'h0020, 48'h0012_FFFF_1234, 8'h33);
    miss("R6 regime1 e2h=tge=1 asid mismatch", 49'h1_0000_7FFF_1234, 2'd1, 16'd9, 16'd0, 1'b1, 1'b1);
    look("R6 regime1 e2h=tge=1 asid match", 49'h1_0000_7FFF_1234, 2'd1, 16'd4, 16'd0, 1'b1, 1'b1,
         1'b1, 1'b0, 16'h0020, 48'h0012_FFFF_1234, 8'h33);
    miss("R3 bit48 compared", 49'h0_0000_7FFF_1234, 2'd1, 16'd4, 16'd0, 1'b0, 1'b0);

    // E3: reserved size code
    fill(4'd6, 49'h0, 48'h0, 8'h77, 2'd3, 2'd0, 16'd0, 1'b0, 16'd0, 1'b0);
    miss("R3 reserved size", 49'h0_0000_0000_0010, 2'd0, 16'd0, 16'd0, 1'b0, 1'b0);

    // E4: regime 0, asid/vmid ignored
    fill(4'd7, 49'h0_0000_0000_5000, 48'h0000_0000_6000, 8'h44, 2'd0, 2'd0, 16'd1, 1'b0, 16'd1, 1'b0);
    look("R7 R8 regime0 ignores ids", 49'h0_0000_0000_5010, 2'd0, 16'd2, 16'd2, 1'b0, 1'b0,
         1'b1, 1'b0, 16'h0080, 48'h0000_0000_6010, 8'h44);

    // E5: 1 GB at idx 9 overlapping E0
    fill(4'd9, 49'h0_1234_4000_0000, 48'h0000_C000_0000, 8'h55, 2'd2, 2'd3, 16'd5, 1'b0, 16'd7, 1'b0);
    look("R9 R11 multi-hit lowest wins", 49'h0_1234_5678_9ABC, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0,
         1'b1, 1'b1, 16'h0001, 48'h0000_0ABC_DABC, 8'h11);
    look("R9 single large page", 49'h0_1234_4000_0010, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0,
         1'b1, 1'b0, 16'h0200, 48'h0000_C000_0010, 8'h55);

    // R10: invalidate together with a write to idx 10
    fill(4'd10, 49'h0_0000_0000_9000, 48'h0000_0000_A000, 8'h66, 2'd0, 2'd0, 16'd0, 1'b0, 16'd0, 1'b1);
    miss("R10 inv clears E0", 49'h0_1234_5678_9ABC, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0);
    miss("R10 inv clears E4", 49'h0_0000_0000_5010, 2'd0, 16'd2, 16'd2, 1'b0, 1'b0);
    miss("R10 inv beats write", 49'h0_0000_0000_9000, 2'd0, 16'd0, 16'd0, 1'b0, 1'b0);

    fill(4'd0, 49'h0_1234_5678_9000, 48'h0000_0ABC_D000, 8'h11, 2'd0, 2'd3, 16'd5, 1'b0, 16'd7, 1'b0);
    look("R2 refill after inv", 49'h0_1234_5678_9004, 2'd3, 16'd5, 16'd7, 1'b0, 1'b0,
         1'b1, 1'b0, 16'h0001, 48'h0000_0ABC_D004, 8'h11);

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule